// File: doc/BRIEF.md
# PHY Management Register Controller

This block lets a host reach the registers of an attached Ethernet PHY through two memory-mapped words. The command word holds the target PHY address, the target register number, a read/write select and sixteen data bits. Writing the command word starts one clause-22 management frame on the two-wire MDC/MDIO link. While the frame runs, a busy flag is high. When a read finishes, the PHY's reply replaces the data field and a read-valid flag goes high. Both flags live in the same word, so the host polls that one location.

A second word stores a 5-bit PHY address for the host's own use. MDC is made from the system clock by a parameter divider and runs only during a frame. Outgoing bits change on the falling MDC edge. Incoming bits are taken on the rising MDC edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both host words read as zero, MDC is low and the MDIO driver is disabled.
- R2: A host write to address 0 while idle is accepted. From the next cycle, busy (bit 28) reads 1. The read/write select (bit 26, 1 = read), register number (bits 25:21), PHY address (bits 20:16) and data (bits 15:0) read back as written. Bits 31:29 read 0.
- R3: MDC is low whenever no frame runs. During a frame its level toggles every HALF_DIV clock cycles, starting low.
- R4: A frame drives these bits, most significant first: 32 ones, then 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register number. The first bit appears in the cycle after acceptance. Each later bit appears just after a falling MDC edge.
- R5: On a write, the turnaround drives 10 and is followed by the 16 data bits. On a read, the driver is disabled from the turnaround (bit 46 of the 64-bit frame) to the end.
- R6: On a read, MDIO is sampled on the 16 rising MDC edges of bits 48 to 63. When the frame ends, the sampled value, MSB first, replaces bits 15:0 and read-valid (bit 27) becomes 1.
- R7: Busy stays high for exactly 128*HALF_DIV cycles. It clears at the falling MDC edge that ends bit 63.
- R8: A command write while busy has no effect on the command word or the frame in progress.
- R9: An accepted command clears read-valid. A write frame leaves read-valid at 0.
- R10: A write to address 1 stores bits 4:0 only. Address 1 reads back those 5 bits, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 1 | Word select: 0 command word, 1 PHY address word |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read view of the selected word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is a command written while a frame is in flight, in particular one that lands on the same cycle as the final falling MDC edge. A cycle-exact model in the bench predicts each MDC edge. The bench uses that model to place a second command in mid-frame and check that every field stays frozen. The PHY's reply is driven from the model's bit counter, so read frames see realistic data on the sampling edges. The bench then checks that the data field and read-valid change only when busy falls.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int BUSY_POS   = 28;
  localparam int RVAL_POS   = 27;
  localparam int OPRD_POS   = 26;

  typedef struct packed {
    logic        op_read;
    logic [4:0]  regn;
    logic [4:0]  phy;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t unpack_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.op_read = w[OPRD_POS];
    c.regn    = w[25:21];
    c.phy     = w[20:16];
    c.data    = w[15:0];
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] payload;
    opc     = c.op_read ? 2'b10 : 2'b01;
    ta      = c.op_read ? 2'b00 : 2'b10;
    payload = c.op_read ? 16'h0000 : c.data;
    return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regn, ta, payload};
  endfunction

  function automatic logic drives_bit(input logic [5:0] idx, input logic op_read);
    return !op_read || (int'(idx) < TA_FIRST);
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        frame_done,
  output logic [5:0]  bit_idx,
  output logic [15:0] rd_capture
);
  logic [FRAME_BITS-1:0] shreg;
  logic                  is_read;
  logic                  last_bit;
  logic                  sample_now;

  assign last_bit   = (bit_idx == 6'(FRAME_BITS - 1));
  assign frame_done = busy && fall_tick && last_bit;
  assign sample_now = busy && rise_tick && is_read && (int'(bit_idx) >= DATA_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      is_read    <= 1'b0;
      bit_idx    <= '0;
      busy       <= 1'b0;
      mdio_o     <= 1'b1;
      mdio_oe    <= 1'b0;
      rd_capture <= '0;
    end else if (!busy) begin
      if (start) begin
        shreg   <= build_frame(cmd);
        is_read <= cmd.op_read;
        bit_idx <= '0;
        busy    <= 1'b1;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (sample_now) rd_capture <= {rd_capture[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 6'd1;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= drives_bit(bit_idx + 6'd1, is_read);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_cmd_t   cmd_q;
  mgmt_cmd_t   cmd_in;
  logic        rvalid;
  logic [4:0]  phy_sel;
  logic        busy;
  logic        cmd_wr;
  logic        cmd_accept;
  logic        frame_done;
  logic        rise_tick;
  logic        fall_tick;
  logic [5:0]  bit_idx;
  logic [15:0] rd_capture;
  logic [31:0] cmd_word;

  assign cmd_in     = unpack_cmd(reg_wdata);
  assign cmd_wr     = reg_wr && !reg_addr;
  assign cmd_accept = cmd_wr && !busy;

  mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(cmd_accept), .cmd(cmd_in),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .frame_done(frame_done), .bit_idx(bit_idx), .rd_capture(rd_capture)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rvalid  <= 1'b0;
      phy_sel <= '0;
    end else begin
      if (reg_wr && reg_addr) phy_sel <= reg_wdata[4:0];
      if (cmd_accept) begin
        cmd_q  <= cmd_in;
        rvalid <= 1'b0;
      end else if (frame_done && cmd_q.op_read) begin
        cmd_q.data <= rd_capture;
        rvalid     <= 1'b1;
      end
    end
  end

  assign cmd_word  = {3'b000, busy, rvalid, cmd_q};
  assign reg_rdata = reg_addr ? {27'd0, phy_sel} : cmd_word;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        rvalid,
  input logic        op_read,
  input logic        fall_tick,
  input logic        frame_done,
  input logic        cmd_wr,
  input logic        cmd_accept,
  input logic [5:0]  bit_idx,
  input logic [31:0] cmd_word
);
  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_tick) |=> $stable(mdio_o));
  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_read && bit_idx >= 6'd46) |-> !mdio_oe);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_done));
  // R6
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $fell(busy));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !frame_done) |=> (busy && $stable(cmd_word[26:16])));
  // R9
  rvalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !rvalid);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .rvalid(rvalid), .op_read(cmd_q.op_read),
  .fall_tick(fall_tick), .frame_done(frame_done), .cmd_wr(cmd_wr),
  .cmd_accept(cmd_accept), .bit_idx(bit_idx), .cmd_word(cmd_word)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;
  bit ended = 0;
  logic [15:0] phy_val = 16'h0000;

  // behavioural reference state
  bit          m_busy, m_mdc, m_rd, m_rvalid;
  int          m_cnt, m_idx;
  logic [4:0]  m_phy, m_reg, m_paddr;
  logic [15:0] m_data, m_cap;
  logic [63:0] m_bits;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // simulated PHY answers from the model's bit counter
  assign mdio_i = (m_busy && m_rd && m_idx >= 48) ? phy_val[63 - m_idx] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_mdc <= 0; m_rd <= 0; m_rvalid <= 0; m_cnt <= 0; m_idx <= 0;
      m_phy <= 0; m_reg <= 0; m_paddr <= 0; m_data <= 0; m_cap <= 0; m_bits <= 0;
    end else begin
      if (reg_wr && reg_addr) m_paddr <= reg_wdata[4:0];
      if (!m_busy) begin
        if (reg_wr && !reg_addr) begin
          m_busy <= 1; m_cnt <= 0; m_mdc <= 0; m_idx <= 0; m_rvalid <= 0;
          m_rd <= reg_wdata[26]; m_reg <= reg_wdata[25:21];
          m_phy <= reg_wdata[20:16]; m_data <= reg_wdata[15:0];
          m_bits[63:32] <= '1;
          m_bits[31:30] <= 2'b01;
          m_bits[29:28] <= reg_wdata[26] ? 2'b10 : 2'b01;
          m_bits[27:23] <= reg_wdata[20:16];
          m_bits[22:18] <= reg_wdata[25:21];
          m_bits[17:16] <= 2'b10;
          m_bits[15:0]  <= reg_wdata[15:0];
        end
      end else if (m_cnt == HALF - 1) begin
        m_cnt <= 0;
        m_mdc <= !m_mdc;
        if (!m_mdc) begin
          if (m_rd && m_idx >= 48) m_cap <= {m_cap[14:0], mdio_i};
        end else if (m_idx == 63) begin
          m_busy <= 0;
          if (m_rd) begin m_data <= m_cap; m_rvalid <= 1; end
        end else begin
          m_idx <= m_idx + 1;
        end
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check("R3 mdc", {31'd0, mdc}, {31'd0, m_mdc});
      check("R5 oe", {31'd0, mdio_oe}, {31'd0, m_busy && (!m_rd || m_idx < 46)});
      if (m_busy && (!m_rd || m_idx < 46))
        check("R4 mdio_o", {31'd0, mdio_o}, {31'd0, m_bits[63 - m_idx]});
      if (reg_addr)
        check("R10 addr word", reg_rdata, {27'd0, m_paddr});
      else
        check("R2 R6 R7 cmd word", reg_rdata,
              {3'b000, m_busy, m_rvalid, m_rd, m_reg, m_phy, m_data});
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic wait_idle();
    while (reg_rdata[28]) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] rg,
                                     input logic [4:0] ph, input logic [15:0] d);
    return {5'd0, rd, rg, ph, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd", reg_rdata, 32'd0);
    check("R1 mdc", {30'd0, mdc, mdio_oe}, 32'd0);
    reg_addr = 1; #1;
    check("R1 addr", reg_rdata, 32'd0);
    reg_addr = 0;
    rst_n = 1;
    @(negedge clk);
    // R10 upper bits dropped
    wr(1, 32'hFFFF_FFE5);
    reg_addr = 1; #1;
    check("R10 masked", reg_rdata, 32'h0000_0005);
    reg_addr = 0;
    // R2 R4 R5 write frame, with R8 write in mid-frame
    wr(0, mk(0, 5'd9, 5'd3, 16'hA5C3) | 32'hF800_0000);
    check("R2 busy set", reg_rdata, {3'b000, 1'b1, 1'b0, mk(0, 5'd9, 5'd3, 16'hA5C3)[26:0]});
    repeat (40) @(negedge clk);
    wr(0, mk(1, 5'd1, 5'd1, 16'h1111));
    check("R8 ignored", {5'd0, reg_rdata[26:0]}, mk(0, 5'd9, 5'd3, 16'hA5C3));
    wait_idle();
    check("R9 no rvalid after write", {31'd0, reg_rdata[27]}, 32'd0);
    // R6 read with reply
    phy_val = 16'h1234;
    wr(0, mk(1, 5'd0, 5'd31, 16'hFFFF));
    repeat (HALF * 128 - 3) @(negedge clk);
    check("R7 still busy", {31'd0, reg_rdata[28]}, 32'd1);
    wait_idle();
    check("R6 read data", reg_rdata, {5'b00001, 1'b1, 5'd0, 5'd31, 16'h1234});
    // R9 new command clears read-valid
    wr(0, mk(0, 5'd2, 5'd4, 16'h0F0F));
    check("R9 cleared", {31'd0, reg_rdata[27]}, 32'd0);
    wait_idle();
    // R6 edge pattern read
    phy_val = 16'h8001;
    wr(0, mk(1, 5'd31, 5'd0, 16'h0000));
    wait_idle();
    check("R6 read edges", reg_rdata[15:0], 16'h8001);
    // R8 command on the final cycle of the frame
    phy_val = 16'h00FF;
    wr(0, mk(1, 5'd7, 5'd7, 16'h0000));
    while (!(m_busy && m_idx == 63 && m_mdc && m_cnt == HALF - 1)) @(negedge clk);
    reg_wr = 1; reg_wdata = mk(0, 5'd5, 5'd5, 16'hDEAD);
    @(negedge clk);
    reg_wr = 0;
    check("R8 final-cycle ignore", reg_rdata, {5'b00001, 1'b1, 5'd7, 5'd7, 16'h00FF});
    repeat (4) @(negedge clk);
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule